// File: doc/BRIEF.md
# I2C Register-Write Target with Strapped Address

This block is an I2C target that fronts a small byte-wide register file. Its 7-bit bus address is not fixed. It is picked from nine consecutive values by two strap inputs. Each strap is three-level (low, high or open) and arrives already encoded as a 2-bit code. SCL and SDA are brought into the system clock domain through a short synchronizer. START and STOP are detected from the synchronized lines, and a byte engine handles the address, command and data phases.

In a write, the controller sends the address byte with R/W = 0 and then a command byte whose low six bits load the register pointer. Every data byte after that is stored at the pointer, and the pointer then advances. In a read, the controller sends the address byte with R/W = 1. The target then shifts out the register at the pointer and advances the pointer after each byte. It stops driving when the controller withholds its acknowledge. SDA is open-drain and is modelled as a single pull-low enable.

Top module: `i2c_strap_reg_target`

## Requirements
- R1: The target address is 0x50 plus an offset set by the straps, with strap codes 00 = low, 01 = high, 10 or 11 = open. The pairs (high strap, low strap) give these offsets: (L,L)=0, (L,H)=1, (H,L)=2, (H,H)=3, (L,open)=4, (open,L)=5, (H,open)=6, (open,H)=7, (open,open)=8.
- R2: When the seven address bits after START do not match, SDA is never pulled and all bytes are ignored until the next START or STOP.
- R3: A matching address byte is acknowledged by pulling SDA low for the ninth SCL clock of that byte.
- R4: In a write, the byte after the address loads the 6-bit register pointer from its bits 5:0, and bits 7:6 have no effect.
- R5: Each data byte of a write (first received bit = bit 7) is stored at the pointer and acknowledged in its ninth clock.
- R6: After each stored byte the pointer increases by one, and it wraps from 63 to 0. The number of data bytes per transfer is unlimited.
- R7: In a read (R/W = 1), the target drives the register at the pointer, bit 7 first, from the SCL low phase after the address acknowledge. It advances the pointer after each byte.
- R8: When the controller leaves a read byte unacknowledged, the target releases SDA and drives nothing more until the next START.
- R9: A START seen in the middle of a transfer restarts address reception, and the pointer is kept, so a repeated START works.
- R10: The SDA pull changes only while SCL is low.
- R11: After reset, SDA is released and every register reads 0x00.
- R12: Pointer values at or above NUM_REGS (default 48) accept and acknowledge writes without storing them, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_scl | input | 1 | SCL line level |
| bus_sda | input | 1 | SDA line level (wired-AND bus) |
| strap_hi | input | 2 | Upper address strap code (00 low, 01 high, 1x open) |
| strap_lo | input | 2 | Lower address strap code (00 low, 01 high, 1x open) |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
A wrong bit count inside a byte shows at once at the ports: the acknowledge pull lands on a clock other than the ninth, or read data slips by one position within the same byte. A wrong register pointer stays hidden until a later read, so every write is followed by a readback through a repeated START. After a NACK or a mismatched address, errors in the idle and ignore states show only as an unexpected SDA pull on the next bytes clocked. For that reason the bench clocks extra bytes after those events and expects to read all ones.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int PTR_W  = 6;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      STRAP_LOW  = 2'b00,
      STRAP_HIGH = 2'b01,
      STRAP_OPEN = 2'b10
   } strap_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_RDATA
   } tgt_state_e;

   // Map a strap pair to an address offset 0..8.
   function automatic logic [3:0] strap_offset(input logic [1:0] hi, input logic [1:0] lo);
      logic [1:0] h;
      logic [1:0] l;
      h = hi[1] ? STRAP_OPEN : hi;
      l = lo[1] ? STRAP_OPEN : lo;
      case ({h, l})
         {STRAP_LOW,  STRAP_LOW } : return 4'd0;
         {STRAP_LOW,  STRAP_HIGH} : return 4'd1;
         {STRAP_HIGH, STRAP_LOW } : return 4'd2;
         {STRAP_HIGH, STRAP_HIGH} : return 4'd3;
         {STRAP_LOW,  STRAP_OPEN} : return 4'd4;
         {STRAP_OPEN, STRAP_LOW } : return 4'd5;
         {STRAP_HIGH, STRAP_OPEN} : return 4'd6;
         {STRAP_OPEN, STRAP_HIGH} : return 4'd7;
         default                  : return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_q;
   logic                   sda_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[g] <= 1'b1;
                  sda_pipe[g] <= 1'b1;
               end else begin
                  scl_pipe[g] <= scl_in;
                  sda_pipe[g] <= sda_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_pipe[g] <= 1'b1;
                  sda_pipe[g] <= 1'b1;
               end else begin
                  scl_pipe[g] <= scl_pipe[g-1];
                  sda_pipe[g] <= sda_pipe[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
   assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR = 7'h50
) (
   input  logic [1:0] strap_hi,
   input  logic [1:0] strap_lo,
   output logic [6:0] dev_addr
);

   generate
      if (int'(BASE_ADDR) + 8 > 127) begin : g_bad_base
         $error("i2c_strap_addr: BASE_ADDR leaves no room for nine addresses");
      end
   endgenerate

   logic [3:0] offset;

   always_comb begin
      offset   = strap_offset(strap_hi, strap_lo);
      dev_addr = BASE_ADDR + {3'b000, offset};
   end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
   import i2c_tgt_pkg::*;
#(
   parameter int NUM_REGS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_addr,
   output logic [BYTE_W-1:0] rd_data
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << PTR_W)) begin : g_bad_depth
         $error("i2c_reg_bank: NUM_REGS must lie in 1..64");
      end
   endgenerate

   logic [NUM_REGS-1:0][BYTE_W-1:0] mem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == PTR_W'(i)) mem[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == PTR_W'(i)) rd_data = mem[i];
      end
   end

   // R12: a write aimed past the last register leaves the bank untouched
   assert_unmapped_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(mem));

endmodule

// File: rtl/i2c_strap_reg_target.sv
module i2c_strap_reg_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] BASE_ADDR   = 7'h50,
   parameter int         NUM_REGS    = 48,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_scl,
   input  logic       bus_sda,
   input  logic [1:0] strap_hi,
   input  logic [1:0] strap_lo,
   output logic       sda_pull_low
);

   localparam int CNT_W   = $clog2(BYTE_W + 2);
   localparam int ACK_BIT = BYTE_W;
   localparam int END_BIT = BYTE_W + 1;

   logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic [6:0]        dev_addr;
   tgt_state_e        state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_shift;
   logic [BYTE_W-1:0] tx_shift;
   logic [PTR_W-1:0]  ptr;
   logic              tx_mode;
   logic              ctrl_nack;
   logic              wr_en;
   logic [BYTE_W-1:0] rd_data;
   logic              at_ack_fall;
   logic              at_end_fall;

   i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(bus_scl), .sda_in(bus_sda),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop));

   i2c_strap_addr #(.BASE_ADDR(BASE_ADDR)) u_addr (
      .strap_hi(strap_hi), .strap_lo(strap_lo), .dev_addr(dev_addr));

   i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
      .wr_data(rx_shift), .rd_addr(ptr), .rd_data(rd_data));

   assign at_ack_fall = scl_fall && !bus_start && !bus_stop && bit_cnt == CNT_W'(ACK_BIT);
   assign at_end_fall = scl_fall && !bus_start && !bus_stop && bit_cnt == CNT_W'(END_BIT);
   assign wr_en       = at_ack_fall && state == ST_WDATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         bit_cnt      <= '0;
         rx_shift     <= '0;
         tx_shift     <= '0;
         ptr          <= '0;
         tx_mode      <= 1'b0;
         ctrl_nack    <= 1'b0;
         sda_pull_low <= 1'b0;
      end else if (bus_start) begin
         state        <= ST_ADDR;
         bit_cnt      <= '0;
         tx_mode      <= 1'b0;
         sda_pull_low <= 1'b0;
      end else if (bus_stop) begin
         state        <= ST_IDLE;
         bit_cnt      <= '0;
         tx_mode      <= 1'b0;
         sda_pull_low <= 1'b0;
      end else if (state != ST_IDLE) begin
         if (scl_rise) begin
            if (bit_cnt < CNT_W'(ACK_BIT)) rx_shift <= {rx_shift[BYTE_W-2:0], sda_s};
            else ctrl_nack <= sda_s;
            bit_cnt <= bit_cnt + 1'b1;
         end else if (at_ack_fall) begin
            unique case (state)
               ST_ADDR: begin
                  if (rx_shift[7:1] == dev_addr) begin
                     sda_pull_low <= 1'b1;
                     state        <= rx_shift[0] ? ST_RDATA : ST_CMD;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_CMD: begin
                  ptr          <= rx_shift[PTR_W-1:0];
                  sda_pull_low <= 1'b1;
                  state        <= ST_WDATA;
               end
               ST_WDATA: begin
                  ptr          <= ptr + 1'b1;
                  sda_pull_low <= 1'b1;
               end
               default: sda_pull_low <= 1'b0;
            endcase
         end else if (at_end_fall) begin
            bit_cnt <= '0;
            if (state == ST_RDATA && (!tx_mode || !ctrl_nack)) begin
               sda_pull_low <= ~rd_data[BYTE_W-1];
               tx_shift     <= {rd_data[BYTE_W-2:0], 1'b0};
               ptr          <= ptr + 1'b1;
               tx_mode      <= 1'b1;
            end else if (state == ST_RDATA) begin
               state        <= ST_IDLE;
               tx_mode      <= 1'b0;
               sda_pull_low <= 1'b0;
            end else begin
               sda_pull_low <= 1'b0;
            end
         end else if (scl_fall && state == ST_RDATA && tx_mode && bit_cnt != '0) begin
            sda_pull_low <= ~tx_shift[BYTE_W-1];
            tx_shift     <= {tx_shift[BYTE_W-2:0], 1'b0};
         end
      end
   end

   // R10: the pull only moves while the synchronized SCL is low
   assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_low) |-> !scl_s);

   // R2: an idle or ignoring target never pulls SDA
   assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull_low);

   // R3: an acknowledge pull outside read data sits only in the ninth clock
   assert_ack_in_ninth_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_low && !tx_mode) |-> (bit_cnt == CNT_W'(ACK_BIT) || bit_cnt == CNT_W'(END_BIT)));

   // R8: a NACK after a sent byte releases SDA on the next cycle
   assert_nack_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end_fall && state == ST_RDATA && tx_mode && ctrl_nack) |=> !sda_pull_low);

   // R6: the pointer wraps from the top value to zero after a stored byte
   assert_ptr_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == '1) |=> ptr == '0);

endmodule

// File: tb/i2c_strap_reg_target_test.sv
`timescale 1ns/1ps
module i2c_strap_reg_target_test;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_ctrl = 1'b1;
   logic [1:0] s_hi = 2'b00;
   logic [1:0] s_lo = 2'b00;
   logic       sda_pull;
   logic       sda_line;
   logic       sampled;
   logic       prev_pull = 1'b0;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   assign sda_line = sda_ctrl & ~sda_pull;

   always #5 clk = ~clk;

   i2c_strap_reg_target uut (
      .clk(clk), .rst_n(rst_n), .bus_scl(scl), .bus_sda(sda_line),
      .strap_hi(s_hi), .strap_lo(s_lo), .sda_pull_low(sda_pull));

   // strap pairs {hi,lo}: 00 low, 01 high, 10 open; index = offset
   localparam logic [3:0] STRAPS [9] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101,
                                         4'b0010, 4'b1000, 4'b0110, 4'b1001, 4'b1010};
   // {command byte, data byte}; readback uses cmd & 0x3F
   localparam logic [15:0] VEC [6] = '{16'h00A5, 16'h073C, 16'h2FFF,
                                       16'hC981, 16'h1000, 16'h1E5A};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_clk(input logic b);
      sda_ctrl = b;
      wait_q();
      scl = 1'b1;
      wait_q();
      sampled = sda_line;
      wait_q();
      scl = 1'b0;
      wait_q();
   endtask

   task automatic i2c_start();
      sda_ctrl = 1'b1;
      wait_q();
      scl = 1'b1;
      wait_q();
      sda_ctrl = 1'b0;
      wait_q();
      scl = 1'b0;
      wait_q();
   endtask

   task automatic i2c_stop();
      sda_ctrl = 1'b0;
      wait_q();
      scl = 1'b1;
      wait_q();
      sda_ctrl = 1'b1;
      wait_q();
      wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) bit_clk(b[i]);
      bit_clk(1'b1);
      acked = !sampled;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] d);
      d = '0;
      for (int i = 0; i < 8; i++) begin
         bit_clk(1'b1);
         d = {d[6:0], sampled};
      end
      bit_clk(!give_ack);
      sda_ctrl = 1'b1;
   endtask

   task automatic write1(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                         output bit all_ack);
      bit a1, a2, a3;
      i2c_start();
      send_byte({a, 1'b0}, a1);
      send_byte(cmd, a2);
      send_byte(d, a3);
      i2c_stop();
      all_ack = a1 & a2 & a3;
   endtask

   task automatic read1(input logic [6:0] a, input logic [7:0] cmd, output logic [7:0] d);
      bit a1;
      i2c_start();
      send_byte({a, 1'b0}, a1);
      send_byte(cmd, a1);
      i2c_start();
      send_byte({a, 1'b1}, a1);
      recv_byte(1'b0, d);
      i2c_stop();
   endtask

   // R10: every change of the pull must fall in an SCL low phase
   always @(negedge clk) begin
      if (rst_n && !done && sda_pull !== prev_pull) chk("R10 pull change with SCL high", int'(scl), 0);
      prev_pull <= sda_pull;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      bit         ok;
      logic [7:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11: reset state
      chk("R11 SDA released after reset", int'(sda_pull), 0);
      read1(7'h50, 8'h20, d);
      chk("R11 register reads zero after reset", d, 8'h00);

      // R1 / R3 / R2: strap table walk
      for (int k = 0; k < 9; k++) begin
         {s_hi, s_lo} = STRAPS[k];
         i2c_start();
         send_byte({7'(7'h50 + k), 1'b0}, ok);
         i2c_stop();
         chk($sformatf("R1 R3 ack at strap offset %0d", k), int'(ok), 1);
         i2c_start();
         send_byte({7'(7'h51 + k), 1'b0}, ok);
         i2c_stop();
         chk($sformatf("R2 no ack for neighbour of offset %0d", k), int'(ok), 0);
      end
      s_hi = 2'b11; s_lo = 2'b01;   // code 11 counts as open: offset 7
      i2c_start();
      send_byte({7'h57, 1'b0}, ok);
      i2c_stop();
      chk("R1 code 11 treated as open", int'(ok), 1);
      s_hi = 2'b00; s_lo = 2'b00;

      // R4 / R5 / R9: vector table, write then readback over repeated START
      foreach (VEC[v]) begin
         write1(7'h50, VEC[v][15:8], VEC[v][7:0], ok);
         chk($sformatf("R5 write acked vector %0d", v), int'(ok), 1);
         read1(7'h50, {2'b00, VEC[v][13:8]}, d);
         chk($sformatf("R4 R5 R9 readback vector %0d", v), d, VEC[v][7:0]);
      end

      // R2: mismatched address ignores the whole transfer
      i2c_start();
      send_byte({7'h57, 1'b0}, ok);
      chk("R2 mismatched address not acked", int'(ok), 0);
      send_byte(8'h01, ok);
      chk("R2 command ignored after mismatch", int'(ok), 0);
      send_byte(8'h99, ok);
      chk("R2 data ignored after mismatch", int'(ok), 0);
      i2c_stop();
      read1(7'h50, 8'h01, d);
      chk("R2 register untouched after mismatch", d, 8'h00);

      // R6 / R7: burst write then burst read
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      send_byte(8'h03, ok);
      send_byte(8'h11, ok);
      send_byte(8'h22, ok);
      send_byte(8'h33, ok);
      i2c_stop();
      chk("R6 burst last byte acked", int'(ok), 1);
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      send_byte(8'h03, ok);
      i2c_start();
      send_byte({7'h50, 1'b1}, ok);
      recv_byte(1'b1, d);
      chk("R7 burst read byte 0", d, 8'h11);
      recv_byte(1'b1, d);
      chk("R7 R6 burst read byte 1", d, 8'h22);
      recv_byte(1'b0, d);
      chk("R7 R6 burst read byte 2", d, 8'h33);
      i2c_stop();

      // R6 / R12: wrap from 63 to 0, unmapped registers
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      send_byte(8'h3F, ok);
      send_byte(8'hEE, ok);
      chk("R12 unmapped write still acked", int'(ok), 1);
      send_byte(8'h77, ok);
      i2c_stop();
      read1(7'h50, 8'h00, d);
      chk("R6 pointer wrapped to register 0", d, 8'h77);
      read1(7'h50, 8'h3F, d);
      chk("R12 unmapped register reads zero", d, 8'h00);
      write1(7'h50, 8'h30, 8'h44, ok);
      read1(7'h50, 8'h30, d);
      chk("R12 write at NUM_REGS dropped", d, 8'h00);

      // R8: NACK releases SDA, further clocks read all ones
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      send_byte(8'h03, ok);
      i2c_start();
      send_byte({7'h50, 1'b1}, ok);
      recv_byte(1'b0, d);
      chk("R8 read before NACK", d, 8'h11);
      chk("R8 SDA released after NACK", int'(sda_pull), 0);
      recv_byte(1'b0, d);
      chk("R8 no drive after NACK", d, 8'hFF);
      i2c_stop();

      // R9: repeated START discards a half-set transfer, pointer set anew
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      send_byte(8'h05, ok);
      i2c_start();
      send_byte({7'h50, 1'b0}, ok);
      chk("R9 address acked after repeated START", int'(ok), 1);
      send_byte(8'h06, ok);
      send_byte(8'h9C, ok);
      i2c_stop();
      read1(7'h50, 8'h06, d);
      chk("R9 write after repeated START", d, 8'h9C);
      read1(7'h50, 8'h05, d);
      chk("R9 register 5 kept", d, 8'h33);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule